// File: doc/BRIEF.md
# Predicate and Flag Unit

This unit sits beside the execute stage of a pipelined core in which every instruction, not only branches, carries a 4-bit predicate taken from instruction bits 31..28. Each cycle it compares that predicate with the stored negative (N), zero (Z), carry (C) and overflow (V) flags. It raises an execute enable when the instruction is allowed to take effect. An instruction whose predicate fails still uses its cycle, but it changes nothing.

The unit also holds the flag register. A data-processing instruction writes its ALU flags only when its set-flags bit is asserted. A compare-type instruction always writes the flags and never writes a result register. A failed instruction writes neither. Flags written at the end of one cycle are the flags tested in the next cycle.

Top module: `cond_unit`

## Requirements
- R1: After reset the flag output `flags` is 4'b0000. Bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: Predicate code 4'b1110 (always) gives `exec_en`=1 whenever `issue_valid` is 1. Code 4'b1111 never gives `exec_en`=1.
- R3: Codes 4'b0000 and 4'b0001 pass when Z=1 and when Z=0 respectively.
- R4: The following codes pass on a single flag: 4'b0010 when C=1, 4'b0011 when C=0, 4'b0100 when N=1, 4'b0101 when N=0, 4'b0110 when V=1 and 4'b0111 when V=0.
- R5: Code 4'b1000 passes when C=1 and Z=0. Code 4'b1001 passes in exactly the opposite case.
- R6: Code 4'b1010 passes when N equals V, and code 4'b1011 when N differs from V. Code 4'b1100 passes when Z=0 and N equals V, and code 4'b1101 in exactly the opposite case.
- R7: An executed instruction with `set_flags`=1 or `is_compare`=1 loads `alu_flags` into `flags`. Any other executed instruction leaves `flags` unchanged.
- R8: An instruction whose predicate fails leaves `flags` unchanged, whatever the values of `set_flags` and `is_compare`.
- R9: `result_we` is 1 exactly when `exec_en` is 1 and `is_compare` is 0.
- R10: While `issue_valid` is 0, `exec_en` and `result_we` are 0 and `flags` does not change.
- R11: A flag write at one rising edge changes the predicate result in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is in the execute slot this cycle |
| cond_field | input | 4 | Predicate code, taken from instruction bits 31..28 |
| set_flags | input | 1 | The instruction asks to write the flags (S bit) |
| is_compare | input | 1 | Compare-type instruction: writes the flags and no result register |
| alu_flags | input | 4 | New N, Z, C, V values from the ALU |
| exec_en | output | 1 | The instruction takes effect this cycle |
| result_we | output | 1 | Write enable for the destination register |
| flags | output | 4 | Current N, Z, C, V |

## Verification
`exec_en` and `result_we` are combinational and follow the inputs within the same cycle. The bench therefore samples them 1 ns after it drives the inputs on the falling edge. `flags` changes only at the next rising edge, so the reference model updates its flags at that edge and compares them at the falling edge that follows. An update is also due to change the predicate result in that following cycle, and the bench tests this by loading the flags and checking the predicate in the next cycle.

// File: rtl/cond_pkg.sv
package cond_pkg;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned FLAG_W = 4;

    // Flag bit positions within the flag vector
    localparam int unsigned FN = 3;
    localparam int unsigned FZ = 2;
    localparam int unsigned FC = 1;
    localparam int unsigned FV = 0;

    // Predicate codes, grouped in pairs: the odd code of a pair is the inverse
    typedef enum logic [CODE_W-1:0] {
        P_ZSET  = 4'h0, P_ZCLR  = 4'h1,
        P_CSET  = 4'h2, P_CCLR  = 4'h3,
        P_NSET  = 4'h4, P_NCLR  = 4'h5,
        P_VSET  = 4'h6, P_VCLR  = 4'h7,
        P_UHI   = 4'h8, P_ULS   = 4'h9,
        P_SGE   = 4'hA, P_SLT   = 4'hB,
        P_SGT   = 4'hC, P_SLE   = 4'hD,
        P_ALW   = 4'hE, P_NEVER = 4'hF
    } pred_e;

    typedef struct packed {
        logic [FLAG_W-1:0] nzcv;
    } flag_state_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [FLAG_W-1:0] nzcv,
    output logic              pass
);
    logic n, z, c, v;
    logic base;
    logic invert;

    assign n = nzcv[FN];
    assign z = nzcv[FZ];
    assign c = nzcv[FC];
    assign v = nzcv[FV];

    // The even code of each pair is tested directly; bit 0 inverts it
    always_comb begin
        unique case (code[CODE_W-1:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = ~(n ^ v);
            3'd6: base = ~z & ~(n ^ v);
            default: base = 1'b1;
        endcase
        invert = code[0];
        pass   = base ^ invert;
    end

    always_comb begin
        a_r2_always: assert (!(code == P_ALW) || pass);
        a_r2_never:  assert (!(code == P_NEVER) || !pass);
        a_r3_eq:     assert (!(code == P_ZSET) || (pass == z));
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_val,
    output logic [FLAG_W-1:0] cur
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.nzcv = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.nzcv;

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur == $past(wr_val)));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cur));
endmodule

// File: rtl/cond_unit.sv
module cond_unit
    import cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [CODE_W-1:0] cond_field,
    input  logic              set_flags,
    input  logic              is_compare,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic              exec_en,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags
);
    logic pass_w;
    logic fwr_w;

    cond_eval u_eval (
        .code (cond_field),
        .nzcv (flags),
        .pass (pass_w)
    );

    always_comb begin
        exec_en   = issue_valid & pass_w;
        result_we = exec_en & ~is_compare;
        fwr_w     = exec_en & (set_flags | is_compare);
    end

    flag_store u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (fwr_w),
        .wr_val (alu_flags),
        .cur    (flags)
    );

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (!exec_en && !result_we));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(flags));
    a_r9_cmp_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        is_compare |-> !result_we);
    a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !exec_en) |=> $stable(flags));
    a_r7_plain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !set_flags && !is_compare) |=> $stable(flags));
endmodule

// File: tb/test_cond_unit.sv
module test_cond_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [3:0] cond_field = 4'h0;
    logic       set_flags = 1'b0;
    logic       is_compare = 1'b0;
    logic [3:0] alu_flags = 4'h0;
    logic       exec_en, result_we;
    logic [3:0] flags;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [3:0] mflags = 4'h0;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    cond_unit i_cond_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .cond_field(cond_field), .set_flags(set_flags),
        .is_compare(is_compare), .alu_flags(alu_flags),
        .exec_en(exec_en), .result_we(result_we), .flags(flags)
    );

    function automatic bit ref_ok(input logic [3:0] cc, input logic [3:0] f);
        bit fn = f[3], fz = f[2], fc = f[1], fv = f[0];
        case (cc)
            4'h0: return fz;               // R3
            4'h1: return !fz;              // R3
            4'h2: return fc;               // R4
            4'h3: return !fc;              // R4
            4'h4: return fn;               // R4
            4'h5: return !fn;              // R4
            4'h6: return fv;               // R4
            4'h7: return !fv;              // R4
            4'h8: return fc && !fz;        // R5
            4'h9: return !fc || fz;        // R5
            4'hA: return fn == fv;         // R6
            4'hB: return fn != fv;         // R6
            4'hC: return !fz && (fn == fv);// R6
            4'hD: return fz || (fn != fv); // R6
            4'hE: return 1'b1;             // R2
            default: return 1'b0;          // R2
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] cc);
        if (cc == 4'h0 || cc == 4'h1) return "R3";
        if (cc <= 4'h7) return "R4";
        if (cc <= 4'h9) return "R5";
        if (cc <= 4'hD) return "R6";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cond %h flags_model %h)",
                     req, act, exp, cond_field, mflags);
        end
    endtask

    // One instruction slot: drive at falling edge, check combinational outputs,
    // advance model at rising edge, then check the registered flags.
    task automatic step(input bit v, input logic [3:0] cc, input bit s,
                        input bit cmp, input logic [3:0] af);
        bit e;
        @(negedge clk);
        issue_valid = v; cond_field = cc; set_flags = s;
        is_compare = cmp; alu_flags = af;
        #1;
        e = v && ref_ok(cc, mflags);
        check(v ? tag_of(cc) : "R10", {3'b0, exec_en}, {3'b0, e});
        check(v ? "R9" : "R10", {3'b0, result_we}, {3'b0, e && !cmp});
        @(posedge clk);
        if (e && (s || cmp)) mflags = af;       // R7, R8
        @(negedge clk);
        check("R7/R8/R11", flags, mflags);
        issue_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", flags, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", flags, 4'h0);

        // Exhaustive: load each flag pattern by compare, then test every code (R11)
        for (int f = 0; f < 16; f++) begin
            step(1, 4'hE, 0, 1, 4'(f));
            for (int c = 0; c < 16; c++) begin
                step(1, 4'(c), 0, 0, 4'h0);
            end
        end

        // R8: failing predicate with S and compare set must not write
        step(1, 4'hE, 1, 0, 4'h4);        // Z=1
        step(1, 4'h1, 1, 0, 4'hB);        // NE fails
        step(1, 4'h1, 0, 1, 4'hB);
        step(1, 4'hF, 1, 1, 4'hB);
        // R7: executed without S leaves flags
        step(1, 4'h0, 0, 0, 4'h9);
        step(1, 4'h0, 1, 0, 4'h9);        // executes, writes
        // R11: the new flags are tested in the very next slot
        step(1, 4'h4, 0, 0, 4'h0);        // MI passes with N=1
        // R10: idle slots ignore everything
        step(0, 4'hE, 1, 1, 4'h0);
        step(0, 4'hE, 1, 0, 4'h6);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            seed = seed * 1664525 + 1013904223;
            r = seed;
            step(r[0] | r[1], r[7:4], r[8], r[9] & r[10], r[15:12]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule